// File: doc/BRIEF.md
# ADC Calibration Sequencer

This block is the digital control for calibrating a delta-sigma converter. The host writes a three-bit calibration command into the control register. The sequencer then runs an offset step, a gain step, or an offset step followed by a gain step. It counts the conversion-cycle strobes that come from the modulator side. At the end of each step, the value on the calibration result bus is loaded into the matching coefficient register. The offset coefficient is aligned to the data word at its MSB, and its LSB weighs 2^-24 of the input span. The gain coefficient resets to unity, which is the MSB set and every other bit clear.

When a calibration finishes, the command field returns to idle by itself and a completion flag is raised. Reading the setup, offset, gain or data register lowers the flag. Reading the control register leaves it as it is, so the host can poll the control register safely. The result bus is a stream qualified by the strobe, and the block takes every strobe it sees. There is no back-pressure: the producer never waits, and a strobe is sampled on the edge where it is high.

Top module: `adc_cal_ctrl`

## Requirements
- R1: After reset the offset register reads 0, the gain register reads 0x800000, and the control register reads 0.
- R2: Command 001 starts an offset step. The first strobe after the write loads cal_result into the offset register and ends the calibration.
- R3: Command 010 starts a gain step. The first strobe after the write loads cal_result into the gain register and ends the calibration.
- R4: Command 011 loads the offset register on the first strobe and the gain register on the second strobe. After the first strobe the flag is still 0 and the command still reads 011.
- R5: The command field, bits [2:0] of the control register at address 0, reads 000 once the last step of a calibration ends.
- R6: The completion flag, bit 3 of the control register, reads 1 once the last step of a calibration ends.
- R7: A read of the setup (address 1), offset (address 2), gain (address 3) or data (address 4) register clears the flag.
- R8: A read of the control register (address 0) leaves the flag unchanged.
- R9: A control register write made while a calibration is running is ignored.
- R10: When a flag-clearing read falls in the same cycle as the end of a calibration, the flag is set.
- R11: A write of a command code 100 to 111 starts nothing, and the command field stays 000.
- R12: While idle, each strobe loads cal_result into the data register. During a calibration the data register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; drives the flag-clearing side effects |
| addr | input | 3 | Register address: 0 control, 1 setup, 2 offset, 3 gain, 4 data |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Read data for addr; combinational |
| conv_strobe | input | 1 | One-cycle pulse per conversion cycle; qualifies cal_result |
| cal_result | input | 24 | Result word sampled when conv_strobe is high |

## Verification
The hardest case to reach is a flag-clearing read that lands in the same clock as the strobe ending a calibration. The bench drives the strobe and an offset read on the same negative edge, then polls the control register, which does not clear the flag, to confirm the flag survived. The middle of a combined calibration is reached by stopping after the first strobe and inspecting the flag, the command and both coefficients before the second strobe is sent.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_OFS = 2'd1, ST_GAIN = 2'd2} cal_state_e;

  localparam int CMD_W = 3;
  localparam logic [CMD_W-1:0] CMD_NONE = 3'd0;
  localparam logic [CMD_W-1:0] CMD_OFS  = 3'd1;
  localparam logic [CMD_W-1:0] CMD_GAIN = 3'd2;
  localparam logic [CMD_W-1:0] CMD_BOTH = 3'd3;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SETUP = 3'd1;
  localparam logic [ADDR_W-1:0] A_OFS   = 3'd2;
  localparam logic [ADDR_W-1:0] A_GAIN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd4;

  function automatic logic read_clears(input logic [ADDR_W-1:0] a);
    return (a == A_SETUP) || (a == A_OFS) || (a == A_GAIN) || (a == A_DATA);
  endfunction

  function automatic logic cmd_valid(input logic [CMD_W-1:0] c);
    return (c == CMD_OFS) || (c == CMD_GAIN) || (c == CMD_BOTH);
  endfunction
endpackage

// File: rtl/cal_seq.sv
module cal_seq
  import adc_cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_in,
  input  logic             strobe,
  output cal_state_e       state,
  output logic [CMD_W-1:0] cmd_q,
  output logic             ofs_load,
  output logic             gain_load,
  output logic             cal_end
);
  always_comb begin
    ofs_load  = (state == ST_OFS) && strobe;
    gain_load = (state == ST_GAIN) && strobe;
    cal_end   = (ofs_load && (cmd_q != CMD_BOTH)) || gain_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cmd_q <= CMD_NONE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmd_wr && cmd_valid(cmd_in)) begin
            cmd_q <= cmd_in;
            state <= (cmd_in == CMD_GAIN) ? ST_GAIN : ST_OFS;
          end
        end
        ST_OFS: begin
          if (strobe) begin
            if (cmd_q == CMD_BOTH) begin
              state <= ST_GAIN;
            end else begin
              state <= ST_IDLE;
              cmd_q <= CMD_NONE;
            end
          end
        end
        ST_GAIN: begin
          if (strobe) begin
            state <= ST_IDLE;
            cmd_q <= CMD_NONE;
          end
        end
        default: begin
          state <= ST_IDLE;
          cmd_q <= CMD_NONE;
        end
      endcase
    end
  end
endmodule

// File: rtl/cal_regs.sv
module cal_regs
  import adc_cal_pkg::*;
#(
  parameter int W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic              ofs_load,
  input  logic              gain_load,
  input  logic              idle,
  input  logic              strobe,
  input  logic [W-1:0]      result,
  output logic [W-1:0]      ofs_q,
  output logic [W-1:0]      gain_q,
  output logic [W-1:0]      setup_q,
  output logic [W-1:0]      data_q
);
  localparam logic [W-1:0] GAIN_UNITY = {1'b1, {(W-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q   <= '0;
      gain_q  <= GAIN_UNITY;
      setup_q <= '0;
      data_q  <= '0;
    end else begin
      if (ofs_load)                      ofs_q <= result;
      else if (wr_en && addr == A_OFS)   ofs_q <= wdata;
      if (gain_load)                     gain_q <= result;
      else if (wr_en && addr == A_GAIN)  gain_q <= wdata;
      if (wr_en && addr == A_SETUP)      setup_q <= wdata;
      if (idle && strobe)                data_q <= result;
    end
  end
endmodule

// File: rtl/done_flag.sv
module done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/adc_cal_ctrl.sv
module adc_cal_ctrl
  import adc_cal_pkg::*;
#(
  parameter int W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic              conv_strobe,
  input  logic [W-1:0]      cal_result
);
  localparam int PAD_W = W - CMD_W - 1;

  cal_state_e       state;
  logic [CMD_W-1:0] cmd_q;
  logic             ofs_load, gain_load, cal_end;
  logic             flag_q, flag_clr;
  logic [W-1:0]     ofs_q, gain_q, setup_q, data_q;

  cal_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(wr_en && addr == A_CTRL), .cmd_in(wdata[CMD_W-1:0]),
    .strobe(conv_strobe), .state(state), .cmd_q(cmd_q),
    .ofs_load(ofs_load), .gain_load(gain_load), .cal_end(cal_end)
  );

  cal_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ofs_load(ofs_load), .gain_load(gain_load), .idle(state == ST_IDLE),
    .strobe(conv_strobe), .result(cal_result),
    .ofs_q(ofs_q), .gain_q(gain_q), .setup_q(setup_q), .data_q(data_q)
  );

  assign flag_clr = rd_en && read_clears(addr);

  done_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(cal_end), .clr_i(flag_clr), .flag_o(flag_q)
  );

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = {{PAD_W{1'b0}}, flag_q, cmd_q};
      A_SETUP: rdata = setup_q;
      A_OFS:   rdata = ofs_q;
      A_GAIN:  rdata = gain_q;
      A_DATA:  rdata = data_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_cal_ctrl_chk.sv
module adc_cal_ctrl_chk
  import adc_cal_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       state,
  input logic [CMD_W-1:0] cmd_q,
  input logic             flag_q,
  input logic             cal_end,
  input logic             wr_en,
  input logic             rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic             conv_strobe
);
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'(ST_OFS) && conv_strobe && cmd_q == CMD_OFS) |=> (flag_q && state == 2'(ST_IDLE)));

  assert_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'(ST_OFS) && conv_strobe && cmd_q == CMD_BOTH) |=> (state == 2'(ST_GAIN) && cmd_q == CMD_BOTH));

  assert_cmd_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cal_end |=> (cmd_q == CMD_NONE));

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && read_clears(addr) && !cal_end) |=> !flag_q);

  assert_ctrl_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CTRL && !cal_end) |=> (flag_q == $past(flag_q)));

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'(ST_IDLE) && !conv_strobe && wr_en && addr == A_CTRL) |=> $stable(cmd_q));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cal_end |=> flag_q);
endmodule

bind adc_cal_ctrl adc_cal_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .state(state), .cmd_q(cmd_q), .flag_q(flag_q),
  .cal_end(cal_end), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .conv_strobe(conv_strobe)
);

// File: tb/adc_cal_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_cal_ctrl_tb_top;
  localparam int W = 24;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, conv_strobe = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [W-1:0] wdata = '0, cal_result = '0, rdata;
  int checks = 0, errors = 0;
  bit done_run = 1'b0;

  always #2.5 clk = ~clk;

  adc_cal_ctrl #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .conv_strobe(conv_strobe), .cal_result(cal_result)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [2:0] a, input logic [W-1:0] exp);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 check(tag, rdata, exp);
    @(negedge clk); rd_en = 1'b0; addr = 3'd0;
  endtask

  task automatic pulse(input logic [W-1:0] r);
    @(negedge clk); conv_strobe = 1'b1; cal_result = r;
    @(negedge clk); conv_strobe = 1'b0;
  endtask

  task automatic t_reset();
    read_chk("R1 offset", 3'd2, 24'h000000);
    read_chk("R1 gain", 3'd3, 24'h800000);
    read_chk("R1 ctrl", 3'd0, 24'h000000);
  endtask

  task automatic t_offset_only();
    write_reg(3'd0, 24'h000001);
    read_chk("R9 ctrl busy ofs", 3'd0, 24'h000001);
    pulse(24'h123456);
    read_chk("R5 R6 ctrl after ofs", 3'd0, 24'h000008);
    read_chk("R8 ctrl read keeps flag", 3'd0, 24'h000008);
    read_chk("R2 offset loaded", 3'd2, 24'h123456);
    read_chk("R7 offset read clears", 3'd0, 24'h000000);
  endtask

  task automatic t_gain_busy_write();
    write_reg(3'd0, 24'h000002);
    write_reg(3'd0, 24'h000001);
    read_chk("R9 write ignored", 3'd0, 24'h000002);
    pulse(24'h654321);
    read_chk("R3 gain loaded", 3'd3, 24'h654321);
    read_chk("R9 offset untouched", 3'd2, 24'h123456);
    read_chk("R7 gain read cleared", 3'd0, 24'h000000);
  endtask

  task automatic t_both();
    write_reg(3'd0, 24'h000003);
    pulse(24'h0000AA);
    read_chk("R4 mid ctrl", 3'd0, 24'h000003);
    read_chk("R4 mid offset", 3'd2, 24'h0000AA);
    read_chk("R4 mid gain", 3'd3, 24'h654321);
    read_chk("R12 data held in cal", 3'd4, 24'h000000);
    pulse(24'h7FFFFF);
    read_chk("R4 R6 end ctrl", 3'd0, 24'h000008);
    read_chk("R4 gain loaded", 3'd3, 24'h7FFFFF);
  endtask

  task automatic t_data_setup_clear();
    read_chk("R7 pre", 3'd0, 24'h000000);
    pulse(24'hABCDEF);
    read_chk("R12 data capture", 3'd4, 24'hABCDEF);
    write_reg(3'd0, 24'h000001);
    pulse(24'h000011);
    read_chk("R7 data read clears", 3'd4, 24'hABCDEF);
    read_chk("R7 after data read", 3'd0, 24'h000000);
    write_reg(3'd1, 24'h5A5A5A);
    write_reg(3'd0, 24'h000002);
    pulse(24'h000022);
    read_chk("R7 setup read", 3'd1, 24'h5A5A5A);
    read_chk("R7 after setup read", 3'd0, 24'h000000);
  endtask

  task automatic t_set_wins();
    write_reg(3'd0, 24'h000001);
    @(negedge clk); conv_strobe = 1'b1; cal_result = 24'h000033; rd_en = 1'b1; addr = 3'd2;
    @(negedge clk); conv_strobe = 1'b0; rd_en = 1'b0; addr = 3'd0;
    read_chk("R10 flag kept", 3'd0, 24'h000008);
    read_chk("R10 offset", 3'd2, 24'h000033);
  endtask

  task automatic t_bad_cmd();
    write_reg(3'd0, 24'h000005);
    read_chk("R11 ctrl idle", 3'd0, 24'h000000);
    pulse(24'h000044);
    read_chk("R11 offset same", 3'd2, 24'h000033);
    read_chk("R11 data took strobe", 3'd4, 24'h000044);
  endtask

  initial begin
    #100000;
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_offset_only();
    t_gain_busy_write();
    t_both();
    t_data_setup_clear();
    t_set_wins();
    t_bad_cmd();
    done_run = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule